// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Multiplier

This block multiplies two signed fixed-point words and returns a word of the same width and layout, together with a flag that warns when the true product is too large for that layout. Each word keeps its sign in the most significant bit. The remaining bits hold the magnitude: integer bits above `FRAC_W` fraction bits in the least significant positions. A negative number therefore differs from its positive counterpart only in the top bit.

The logic is purely combinational, with no clock and no state. The two magnitudes are multiplied to a double-width product. That product is shifted right by `FRAC_W` to return to the operand scale, and the low fraction bits are dropped rather than rounded. The kept slice is as wide as the operand magnitude. If any product bit above that slice is set, `ovf_o` goes high. The result is not clamped in that case: it carries the wrapped low bits. A zero result always has a cleared sign bit.

Top module: `fxp_sm_mul`

## Requirements
- R1: The result magnitude `prod_o[WORD_W-2:0]` equals `floor(|a|*|b| / 2^FRAC_W) mod 2^(WORD_W-1)`, where |x| is bits `[WORD_W-2:0]` of the operand read as an unsigned integer.
- R2: When the result magnitude is nonzero, the result sign bit `prod_o[WORD_W-1]` equals the XOR of the operand sign bits `a_i[WORD_W-1]` and `b_i[WORD_W-1]`.
- R3: When the result magnitude is zero, the result sign bit is 0, including when an operand is negative zero or when truncation removes every bit of a nonzero product.
- R4: `ovf_o` is 1 exactly when `|a|*|b| >= 2^(WORD_W-1+FRAC_W)`, that is, when the true product cannot be held in the output format.
- R5: Fraction bits below the output resolution are truncated toward zero, never rounded up. For example, a product whose exact value is 0.999 LSB yields magnitude 0.
- R6: The outputs depend only on the present inputs: a new input pair is reflected within the same time step, with no clock edge.
- R7: On overflow the result is not saturated. It carries the wrapped magnitude given by R1, with the sign given by R2 and R3.
- R8: Multiplying by the value one (`1 << FRAC_W`, sign 0) returns the other operand unchanged, with `ovf_o` low, unless that operand is negative zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WORD_W | First operand: sign bit, then integer bits, then FRAC_W fraction bits |
| b_i | input | WORD_W | Second operand, same layout |
| prod_o | output | WORD_W | Product in the operand layout, truncated |
| ovf_o | output | 1 | High when the exact product exceeds the output range |

## Verification
The bound checker tests every input change for the properties that hold in all cases. No negative zero ever appears. The sign of a nonzero result always follows the XOR of the operand signs. A zero operand forces a zero result with no overflow. Multiplying by one is the identity. The exact truncated magnitude and the overflow boundary need a reference product, so only the bench's scenarios show them. Those scenarios are the directed edge values (maximum magnitudes, a product landing exactly on the overflow threshold, sub-LSB products) and the seeded random pairs, which are weighted toward small magnitudes so that results both in range and out of range occur.

// File: rtl/fxp_sm_mul.sv
module fxp_sm_mul #(
  parameter int FRAC_W = 8,
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] prod_o,
  output logic              ovf_o
);
  localparam int MAG_W  = WORD_W - 1;
  localparam int FULL_W = 2 * MAG_W;
  localparam int TOP_LO = FRAC_W + MAG_W;

  logic [MAG_W-1:0]  a_mag, b_mag, kept;
  logic [FULL_W-1:0] full;
  logic              sgn;

  assign a_mag = a_i[MAG_W-1:0];
  assign b_mag = b_i[MAG_W-1:0];
  assign full  = FULL_W'(a_mag) * FULL_W'(b_mag);
  assign kept  = full[TOP_LO-1:FRAC_W];
  assign sgn   = (a_i[WORD_W-1] ^ b_i[WORD_W-1]) & (|kept);

  generate
    if (TOP_LO < FULL_W) begin : g_hi
      assign ovf_o = |full[FULL_W-1:TOP_LO];
    end else begin : g_nohi
      assign ovf_o = 1'b0;
    end
  endgenerate

  assign prod_o = {sgn, kept};
endmodule

module fxp_sm_mul_chk #(
  parameter int FRAC_W = 8,
  parameter int WORD_W = 16
) (
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] prod_o,
  input logic              ovf_o
);
  localparam int MAG_W = WORD_W - 1;
  localparam logic [MAG_W-1:0] ONE = MAG_W'(1) << FRAC_W;

  always_comb begin
    p_no_neg_zero_r3: assert (!prod_o[WORD_W-1] || (|prod_o[MAG_W-1:0]))
      else $error("negative zero on output");
    if (|prod_o[MAG_W-1:0])
      p_sign_xor_r2: assert (prod_o[WORD_W-1] == (a_i[WORD_W-1] ^ b_i[WORD_W-1]))
        else $error("sign mismatch");
    if (a_i[MAG_W-1:0] == '0 || b_i[MAG_W-1:0] == '0)
      p_zero_operand_r4: assert (!ovf_o && prod_o == '0)
        else $error("zero operand gave nonzero result or overflow");
    if (b_i == {1'b0, ONE} && a_i[MAG_W-1:0] != '0)
      p_times_one_r8: assert (prod_o == a_i && !ovf_o)
        else $error("multiply by one not identity");
  end
endmodule

bind fxp_sm_mul fxp_sm_mul_chk #(.FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .prod_o(prod_o), .ovf_o(ovf_o)
);

// File: tb/tb_fxp_sm_mul.sv
`timescale 1ns/1ps
module tb_fxp_sm_mul;
  localparam int FRAC_W = 8;
  localparam int WORD_W = 16;
  localparam int MAG_W  = WORD_W - 1;

  logic clk = 1'b0;
  logic [WORD_W-1:0] a, b, prod;
  logic ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fxp_sm_mul #(.FRAC_W(FRAC_W), .WORD_W(WORD_W)) dut (
    .a_i(a), .b_i(b), .prod_o(prod), .ovf_o(ovf)
  );

  function automatic logic [WORD_W:0] ref_mul(logic [WORD_W-1:0] x, logic [WORD_W-1:0] y);
    longint unsigned xm, ym, fp, mag;
    logic s, o;
    xm  = longint'(x[MAG_W-1:0]);
    ym  = longint'(y[MAG_W-1:0]);
    fp  = xm * ym;
    mag = (fp >> FRAC_W) & ((64'd1 << MAG_W) - 1);
    o   = (fp >> (FRAC_W + MAG_W)) != 0;
    s   = (x[WORD_W-1] ^ y[WORD_W-1]) && (mag != 0);
    return {o, s, mag[MAG_W-1:0]};
  endfunction

  task automatic apply(input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y, input string tag);
    logic [WORD_W:0] e;
    a = x; b = y;
    #1;
    e = ref_mul(x, y);
    checks++;
    if (prod !== e[WORD_W-1:0] || ovf !== e[WORD_W]) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual prod=%h ovf=%b expected prod=%h ovf=%b",
               tag, x, y, prod, ovf, e[WORD_W-1:0], e[WORD_W]);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(logic s, int unsigned m);
    return {s, MAG_W'(m)};
  endfunction

  localparam int unsigned ONE = 1 << FRAC_W;
  localparam int unsigned MAXM = (1 << MAG_W) - 1;

  initial begin
    void'($urandom(32'h1357));
    a = '0; b = '0;
    @(negedge clk);
    apply('0, '0, "R1 reset-state zero");
    apply(mk(0, 3*ONE), mk(0, 2*ONE), "R1 3*2");
    apply(mk(1, 3*ONE), mk(0, ONE/2), "R2 neg*pos");
    apply(mk(1, 5*ONE), mk(1, 7*ONE), "R2 neg*neg");
    apply(mk(1, 0), mk(0, 9*ONE), "R3 negative zero operand");
    apply(mk(1, 1), mk(0, ONE-1), "R5 sub-LSB truncates to zero, R3 sign clear");
    apply(mk(0, 3), mk(0, ONE/2+1), "R5 truncation toward zero");
    apply(mk(0, 1 << (MAG_W-1)), mk(0, ONE), "R4 at boundary below");
    apply(mk(0, 1 << (MAG_W-1)), mk(0, 2*ONE), "R4 exact threshold");
    apply(mk(1, MAXM), mk(0, MAXM), "R7 max magnitudes wrap");
    apply(mk(0, 200*ONE), mk(1, 3*ONE), "R7 overflow unclamped");
    apply(mk(1, 1234), mk(0, ONE), "R8 times one");
    apply(mk(0, MAXM), mk(0, ONE), "R8 max times one");
    apply(mk(0, 6*ONE), mk(1, 4*ONE), "R6 first value");
    apply(mk(0, 2*ONE), mk(1, 4*ONE), "R6 change with no clock edge");
    for (int i = 0; i < 3000; i++) begin
      int unsigned sh1 = $urandom_range(MAG_W, 0);
      int unsigned sh2 = $urandom_range(MAG_W, 0);
      logic [WORD_W-1:0] x = WORD_W'($urandom);
      logic [WORD_W-1:0] y = WORD_W'($urandom);
      x[MAG_W-1:0] = x[MAG_W-1:0] >> sh1;
      y[MAG_W-1:0] = y[MAG_W-1:0] >> sh2;
      if (i % 2 == 0) @(negedge clk);
      apply(x, y, "R1 R2 R3 R4 random");
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule